// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

This block decides which of five software localities currently owns a shared command path. Every locality sees a private 8-bit ownership register. That register sits in its own 4 KiB bank of a simple memory-mapped bus, and the bank number is taken from the upper address bits. A locality asks for ownership by setting a request flag. It reads back whether it holds the path and whether some other locality is queued behind it. It gives the path up by writing a relinquish flag.

Ownership moves only when it is free or released; no time slicing takes place. Requests that arrive while the path is held are remembered. On release they are served, and the highest-numbered waiting locality goes first. The arbiter drives the identity of the current owner to neighbouring blocks. It also emits a one-cycle change pulse whenever ownership moves, including the move to the idle state.

Top module: `loc_arb_top`

## Requirements
- R1: After reset no locality is active, no request is waiting, `loc_change` is low, and the ownership register of every locality 0 to 4 reads 0x80.
- R2: `bus_addr[15:12]` selects the locality and the ownership register is at bank offset 0x000. Reads of any other offset, or of banks 5 to 15, return 0x00. Writes there change nothing.
- R3: Ownership register read layout: bit 7 always 1 (contents valid); bit 5 set when this locality owns the path; bit 2 set when any locality other than this one has a waiting request; bit 1 set when this locality's own request is waiting; all other bits 0.
- R4: Writing a 1 to bit 1 while no locality owns the path grants that locality. `active_valid`/`active_loc` show the grant after the next rising clock edge.
- R5: Writing a 1 to bit 1 from a non-owner while another locality owns the path records a waiting request. The owner does not change.
- R6: Writing a 1 to bit 5 from the owner releases the path. In the same clock edge the path goes to a waiting locality if there is one; otherwise it goes idle.
- R7: Bit 5 written by a locality that is not the owner is ignored. Bit 1 written by the owner is ignored, also when it is in the same write as bit 5.
- R8: When several localities are waiting at a grant, the highest-numbered one wins.
- R9: `loc_change` is high for exactly the one cycle after each clock edge that changes the owner or the idle/owned state, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access strobe, one cycle per write |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address; bits 15:12 select the locality bank |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| active_valid | output | 1 | Some locality owns the path |
| active_loc | output | 3 | Owning locality, meaningful while `active_valid` is high |
| loc_change | output | 1 | One-cycle pulse on every ownership change |

## Verification
The two functions that share a clock edge are the owner's release and the handover to a queued locality. That edge also raises the change pulse. The bench provokes it by queuing three requests behind an owner and then releasing. It also sends a single write that carries both the relinquish and the request flag from the owner. The bench judges the outcome against a behavioural model of owner, waiting set and pulse that is compared on every clock. It also reads the per-locality registers directly, to see that the released locality was not queued again.

// File: rtl/loc_arb_pkg.sv
`timescale 1ns/1ps
package loc_arb_pkg;
   // bit positions inside the per-locality ownership register
   localparam int unsigned OWN_VALID_BIT = 7;
   localparam int unsigned OWN_HELD_BIT  = 5;
   localparam int unsigned OWN_WAIT_BIT  = 2;
   localparam int unsigned OWN_ASK_BIT   = 1;

   // highest set bit of a request vector
   function automatic int unsigned top_index(input logic [31:0] vec, input int unsigned n);
      int unsigned idx;
      idx = 0;
      for (int unsigned i = 0; i < n; i++)
         if (vec[i]) idx = i;
      return idx;
   endfunction
endpackage

// File: rtl/loc_arb_decode.sv
`timescale 1ns/1ps
module loc_arb_decode #(
   parameter int NUM_LOC  = 5,
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int BANK_LSB = 12,
   parameter int LOC_W    = 3
) (
   input  logic                bus_valid,
   input  logic                bus_write,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [NUM_LOC-1:0]  ask_stb,
   output logic [NUM_LOC-1:0]  drop_stb,
   output logic                rd_hit,
   output logic [LOC_W-1:0]    rd_sel
);
   import loc_arb_pkg::*;
   localparam int BANK_W = ADDR_W - BANK_LSB;

   logic [BANK_W-1:0] bank;
   logic              at_reg;
   logic              wr_go;
   logic              unused_wdata;

   assign bank         = bus_addr[ADDR_W-1:BANK_LSB];
   assign at_reg       = (bus_addr[BANK_LSB-1:0] == '0);
   assign wr_go        = bus_valid && bus_write && at_reg;
   assign unused_wdata = ^bus_wdata;

   for (genvar g = 0; g < NUM_LOC; g++) begin : g_bank
      logic sel;
      assign sel         = (bank == BANK_W'(g));
      assign ask_stb[g]  = wr_go && sel && bus_wdata[OWN_ASK_BIT];
      assign drop_stb[g] = wr_go && sel && bus_wdata[OWN_HELD_BIT];
   end

   assign rd_hit = at_reg && (bank < BANK_W'(NUM_LOC));
   assign rd_sel = LOC_W'(bank);
endmodule

// File: rtl/loc_arb_core.sv
`timescale 1ns/1ps
module loc_arb_core #(
   parameter int NUM_LOC = 5,
   parameter int LOC_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_LOC-1:0] ask_stb,
   input  logic [NUM_LOC-1:0] drop_stb,
   output logic               own_v,
   output logic [LOC_W-1:0]   own_id,
   output logic [NUM_LOC-1:0] wait_vec,
   output logic               chg
);
   import loc_arb_pkg::*;

   logic               own_v_q, own_v_d;
   logic [LOC_W-1:0]   own_id_q, own_id_d;
   logic [NUM_LOC-1:0] wait_q, wait_d;
   logic               chg_q, chg_d;
   logic [NUM_LOC-1:0] owner_mask, fresh, pool, win_mask;
   logic [LOC_W-1:0]   win;
   logic               release_now;

   always_comb begin
      for (int i = 0; i < NUM_LOC; i++)
         owner_mask[i] = own_v_q && (own_id_q == LOC_W'(i));
      fresh       = ask_stb & ~owner_mask;
      release_now = |(drop_stb & owner_mask);
      pool        = wait_q | fresh;
      win         = LOC_W'(top_index(32'(pool), NUM_LOC));
      for (int i = 0; i < NUM_LOC; i++)
         win_mask[i] = (win == LOC_W'(i));

      own_v_d  = own_v_q;
      own_id_d = own_id_q;
      wait_d   = pool;
      if (!own_v_q || release_now) begin
         if (|pool) begin
            own_v_d  = 1'b1;
            own_id_d = win;
            wait_d   = pool & ~win_mask;
         end else begin
            own_v_d  = 1'b0;
         end
      end
      chg_d = (own_v_d != own_v_q) || (own_v_d && (own_id_d != own_id_q));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         own_v_q  <= 1'b0;
         own_id_q <= '0;
         wait_q   <= '0;
         chg_q    <= 1'b0;
      end else begin
         own_v_q  <= own_v_d;
         own_id_q <= own_id_d;
         wait_q   <= wait_d;
         chg_q    <= chg_d;
      end
   end

   assign own_v    = own_v_q;
   assign own_id   = own_id_q;
   assign wait_vec = wait_q;
   assign chg      = chg_q;

   // R4: an idle path is granted on the very next edge
   a_r4_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (!own_v_q && |ask_stb) |=> own_v_q);
   // R4: nobody waits while the path is idle
   a_r4_idle_no_waiters: assert property (@(posedge clk) disable iff (!rst_n)
      !own_v_q |-> (wait_q == '0));
   // R5 / R7: without any relinquish write the owner stays put
   a_r5_owner_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (own_v_q && !(|drop_stb)) |=> (own_v_q && $stable(own_id_q)));
   // R7: the owner is never also queued
   a_r7_owner_not_waiting: assert property (@(posedge clk) disable iff (!rst_n)
      own_v_q |-> !(|(wait_q & owner_mask)));
   // R9: every ownership move is flagged
   a_r9_move_flagged: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({own_v_q, own_id_q}) |-> chg_q);
   // R9: no pulse without a move
   a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      chg_q |-> !$stable({own_v_q, own_id_q}));
endmodule

// File: rtl/loc_arb_view.sv
`timescale 1ns/1ps
module loc_arb_view #(
   parameter int NUM_LOC = 5,
   parameter int DATA_W  = 8,
   parameter int LOC_W   = 3
) (
   input  logic               own_v,
   input  logic [LOC_W-1:0]   own_id,
   input  logic [NUM_LOC-1:0] wait_vec,
   input  logic               rd_hit,
   input  logic [LOC_W-1:0]   rd_sel,
   output logic [DATA_W-1:0]  rdata
);
   import loc_arb_pkg::*;

   logic [DATA_W-1:0] word [NUM_LOC];

   for (genvar g = 0; g < NUM_LOC; g++) begin : g_word
      logic [NUM_LOC-1:0] others;
      assign others = wait_vec & ~(NUM_LOC'(1) << g);
      always_comb begin
         word[g]                = '0;
         word[g][OWN_VALID_BIT] = 1'b1;
         word[g][OWN_HELD_BIT]  = own_v && (own_id == LOC_W'(g));
         word[g][OWN_WAIT_BIT]  = |others;
         word[g][OWN_ASK_BIT]   = wait_vec[g];
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_LOC; i++)
         if (rd_hit && (rd_sel == LOC_W'(i))) rdata = word[i];
   end
endmodule

// File: rtl/loc_arb_top.sv
`timescale 1ns/1ps
module loc_arb_top #(
   parameter int  NUM_LOC  = 5,
   parameter int  ADDR_W   = 16,
   parameter int  DATA_W   = 8,
   parameter int  BANK_LSB = 12,
   localparam int LOC_W    = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              active_valid,
   output logic [LOC_W-1:0]  active_loc,
   output logic              loc_change
);
   localparam int BANK_W = ADDR_W - BANK_LSB;

   if (NUM_LOC < 2 || NUM_LOC > 32) begin : g_bad_count
      $error("loc_arb_top: NUM_LOC must lie in 2..32");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("loc_arb_top: DATA_W must be at least 8");
   end
   if (BANK_LSB < 1 || BANK_W < 1 || BANK_W > 8) begin : g_bad_bank
      $error("loc_arb_top: bank field must be 1..8 bits wide");
   end else if (NUM_LOC >= (1 << BANK_W) || LOC_W > BANK_W) begin : g_bad_fit
      $error("loc_arb_top: bank field too narrow for NUM_LOC");
   end

   logic [NUM_LOC-1:0] ask_stb, drop_stb, wait_vec;
   logic               rd_hit;
   logic [LOC_W-1:0]   rd_sel;

   loc_arb_decode #(.NUM_LOC(NUM_LOC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                    .BANK_LSB(BANK_LSB), .LOC_W(LOC_W)) u_decode (
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .ask_stb(ask_stb), .drop_stb(drop_stb),
      .rd_hit(rd_hit), .rd_sel(rd_sel));

   loc_arb_core #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_core (
      .clk(clk), .rst_n(rst_n), .ask_stb(ask_stb), .drop_stb(drop_stb),
      .own_v(active_valid), .own_id(active_loc), .wait_vec(wait_vec),
      .chg(loc_change));

   loc_arb_view #(.NUM_LOC(NUM_LOC), .DATA_W(DATA_W), .LOC_W(LOC_W)) u_view (
      .own_v(active_valid), .own_id(active_loc), .wait_vec(wait_vec),
      .rd_hit(rd_hit), .rd_sel(rd_sel), .rdata(bus_rdata));

   // R2: outside the register, reads return zero
   a_r2_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[BANK_LSB-1:0] != '0) |-> (bus_rdata == '0));
   // R6: owner release with nobody waiting leaves the path idle
   a_r6_release_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (active_valid && |(drop_stb & (NUM_LOC'(1) << active_loc))
       && (wait_vec == '0) && !(|ask_stb)) |=> !active_valid);
endmodule

// File: tb/loc_arb_top_tb_top.sv
`timescale 1ns/1ps
module loc_arb_top_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_valid = 1'b0;
   logic       bus_write = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       active_valid;
   logic [2:0] active_loc;
   logic       loc_change;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit model_on = 1'b0;

   // behavioural reference state
   int m_owner = -1;
   bit m_wait [5];
   bit m_chg = 1'b0;

   always #2.5 clk = ~clk;

   loc_arb_top dut_i (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .active_valid(active_valid), .active_loc(active_loc), .loc_change(loc_change));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int exp_word(input logic [15:0] a);
      int b, w;
      b = int'(a[15:12]);
      if (a[11:0] != 12'h000 || b > 4) return 0;
      w = 8'h80;
      if (m_owner == b) w |= 8'h20;
      for (int i = 0; i < 5; i++) if (i != b && m_wait[i]) w |= 8'h04;
      if (m_wait[b]) w |= 8'h02;
      return w;
   endfunction

   // reference model: advances on every rising edge
   always @(posedge clk) begin
      int prev, b;
      bit hit, rel;
      if (!rst_n) begin
         m_owner = -1;
         for (int i = 0; i < 5; i++) m_wait[i] = 1'b0;
         m_chg = 1'b0;
      end else begin
         prev = m_owner;
         b = int'(bus_addr[15:12]);
         hit = bus_valid && bus_write && bus_addr[11:0] == 12'h000 && b < 5;
         rel = hit && bus_wdata[5] && b == m_owner;
         if (hit && bus_wdata[1] && b != m_owner) m_wait[b] = 1'b1;
         if (m_owner < 0 || rel) begin
            m_owner = -1;
            for (int i = 4; i >= 0; i--)
               if (m_owner < 0 && m_wait[i]) begin
                  m_owner = i;
                  m_wait[i] = 1'b0;
               end
         end
         m_chg = (m_owner != prev);
      end
   end

   // per-cycle comparison, away from the rising edge
   always @(negedge clk) begin
      if (model_on && rst_n && !done) begin
         chk(active_valid == (m_owner >= 0), "R6 owner valid", active_valid, m_owner >= 0);
         if (m_owner >= 0)
            chk(int'(active_loc) == m_owner, "R8 owner id", active_loc, m_owner);
         chk(loc_change == m_chg, "R9 change pulse", loc_change, m_chg);
         chk(int'(bus_rdata) == exp_word(bus_addr), "R3 read view", bus_rdata, exp_word(bus_addr));
      end
   end

   task automatic wr(input int bank, input int off, input logic [7:0] d);
      @(posedge clk); #1;
      bus_valid = 1'b1; bus_write = 1'b1;
      bus_addr = {4'(bank), 12'(off)}; bus_wdata = d;
      @(posedge clk); #1;
      bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
      @(negedge clk);
   endtask

   task automatic rd(input int bank, input int off, input int exp, input string tag);
      @(posedge clk); #1;
      bus_addr = {4'(bank), 12'(off)};
      @(negedge clk);
      chk(int'(bus_rdata) == exp, tag, bus_rdata, exp);
   endtask

   task automatic own(input bit v, input int id, input bit pulse, input string tag);
      chk(active_valid == v, tag, active_valid, v);
      if (v) chk(int'(active_loc) == id, tag, active_loc, id);
      chk(loc_change == pulse, tag, loc_change, pulse);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      @(negedge clk);
      own(1'b0, 0, 1'b0, "R1 during reset");
      @(posedge clk); #1;
      rst_n = 1'b1;
      model_on = 1'b1;
      @(negedge clk);
      own(1'b0, 0, 1'b0, "R1 after reset");
      for (int b = 0; b < 5; b++) rd(b, 0, 8'h80, "R1 reset view");
      rd(5, 0, 8'h00, "R2 bank beyond range");
      rd(0, 12'h018, 8'h00, "R2 other offset");

      wr(2, 0, 8'h02);
      own(1'b1, 2, 1'b1, "R4 idle grant");
      rd(2, 0, 8'hA0, "R3 owner view");

      wr(1, 0, 8'h02);
      own(1'b1, 2, 1'b0, "R5 queued behind owner");
      rd(2, 0, 8'hA4, "R3 owner sees waiter");
      rd(1, 0, 8'h82, "R3 own request waiting");
      wr(4, 0, 8'h02);
      wr(0, 0, 8'h02);

      wr(5, 0, 8'h02);
      wr(3, 12'h018, 8'h02);
      rd(3, 0, 8'h84, "R2 stray writes ignored");

      wr(3, 0, 8'h20);
      own(1'b1, 2, 1'b0, "R7 foreign release ignored");
      wr(2, 0, 8'h02);
      rd(2, 0, 8'hA4, "R7 owner request ignored");

      wr(2, 0, 8'h20);
      own(1'b1, 4, 1'b1, "R6 R8 handover to highest");
      rd(2, 0, 8'h84, "R6 releaser not queued");

      wr(4, 0, 8'h22);
      own(1'b1, 1, 1'b1, "R7 R8 combined release");
      rd(4, 0, 8'h84, "R7 combined request dropped");

      wr(1, 0, 8'h20);
      own(1'b1, 0, 1'b1, "R6 handover to last waiter");
      wr(0, 0, 8'h20);
      own(1'b0, 0, 1'b1, "R9 change to idle");
      rd(0, 0, 8'h80, "R6 idle view");

      wr(3, 0, 8'h02);
      own(1'b1, 3, 1'b1, "R4 second grant");
      wr(3, 0, 8'h20);
      own(1'b0, 0, 1'b1, "R9 back to idle");
      @(negedge clk);
      own(1'b0, 0, 1'b0, "R9 pulse lasts one cycle");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule